// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column addresses for one SDRAM burst. The command logic presents a starting column together with a start pulse. The block then puts out one column per clock, in the order set by the burst type. It raises a last flag on the final beat of a fixed-length burst. A stop input ends a burst early at any length. In full-page mode the burst wraps through every column of the row and runs until it is stopped.

The block also decodes the mode register word it is given. The result is the CAS latency, the burst length in beats, the ordering and a legality flag, which the surrounding read and write logic uses. The burst settings are captured when a burst starts, so a later change of the mode word does not disturb a burst that is already running. A new start may arrive on any clock and restarts the sequence.

Top module: `sdram_burst_colgen`

## Requirements
- R1: The mode word is decoded combinationally. Bits 2:0 select the burst length: 000=1, 001=2, 010=4, 011=8, 111=full page (256 beats), and any other code is illegal and is treated as 1 beat. Bit 3 selects the ordering (0 sequential, 1 interleaved) and is forced to sequential for full page. Bits 6:4 give the CAS latency, where 1, 2 and 3 are legal and any other value gives `cas_lat`=0. `mode_legal` is high only when both the length field and the latency field are legal.
- R2: A start sampled on a rising edge makes `col_valid` high after that edge, with `col_out` equal to the sampled `start_col`.
- R3: In sequential order, the low log2(BL) bits of the column count upward from the start value and wrap within the burst, while the upper bits stay at their start value.
- R4: In interleaved order, on beat k the low log2(BL) bits equal the start's low bits XOR k, and the upper bits stay fixed.
- R5: A full-page burst steps the column up by one each clock, wrapping from 255 to 0. It never asserts `col_last` and keeps running until it is stopped or restarted.
- R6: `col_last` is high exactly on the final beat of a fixed-length burst. For BL=1 this is the first beat. `col_valid` is low on the clock after the last beat unless a new start arrives.
- R7: A stop sampled while a burst is running and no start is present makes `col_valid` low after that edge. A stop sampled while the block is idle has no effect.
- R8: A start sampled during a running burst restarts the sequence from the new column. Start takes precedence over stop in the same cycle.
- R9: During and after a synchronous active-low reset, `col_valid` and `col_last` are low.
- R10: The burst length and ordering are captured at start. Changing `mode_word` during a burst does not alter the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_word | input | 7 | Mode register word to decode |
| start | input | 1 | Begin a burst at `start_col` |
| start_col | input | 8 | First column of the burst |
| stop | input | 1 | End the running burst |
| col_out | output | 8 | Column address of the current beat |
| col_valid | output | 1 | A burst beat is present on `col_out` |
| col_last | output | 1 | Final beat of a fixed-length burst |
| cas_lat | output | 2 | Decoded CAS latency (0 when illegal) |
| burst_beats | output | 9 | Decoded burst length in beats |
| interleave | output | 1 | Decoded ordering is interleaved |
| full_page | output | 1 | Decoded length is full page |
| mode_legal | output | 1 | Mode word fields are legal |

## Verification
The decode outputs have no register in their path. They are checked one time step after `mode_word` is changed, with no clock edge in between. Every burst output is due one edge after the inputs that caused it: the first column on the edge that samples start, each further beat one edge later, and the idle state on the edge that samples stop or follows the last beat. The bench changes its inputs just after a falling edge and updates a behavioural model on each rising edge. It then compares valid, last and column on every falling edge, so each sample is taken half a period after the edge that produced it.

// File: rtl/sdram_colgen_pkg.sv
// Shared types and field positions for the burst column generator.
// Assumes a mode word of at least 7 bits with the fields given in the brief.
package sdram_colgen_pkg;
    localparam int LEN_LSB   = 0;
    localparam int TYPE_BIT  = 3;
    localparam int CAS_LSB   = 4;
    localparam logic [2:0] LEN_CODE_FULL = 3'b111;

    // Burst settings captured at start
    typedef struct packed {
        logic       full_page;
        logic       interleave;
        logic [1:0] len_log2;
    } burst_cfg_t;
endpackage

// File: rtl/sdram_mode_decode.sv
// Decodes the mode word into burst settings, CAS latency and a legality flag.
// Purely combinational. Illegal length codes fall back to one beat.
module sdram_mode_decode
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 7
) (
    input  logic [MODE_W-1:0] mode_word,
    output burst_cfg_t        cfg,
    output logic [1:0]        cas_lat,
    output logic [COL_W:0]    burst_beats,
    output logic              mode_legal
);
    logic [2:0] len_code;
    logic [2:0] cas_code;
    logic       len_ok;
    logic       cas_ok;

    assign len_code = mode_word[LEN_LSB +: 3];
    assign cas_code = mode_word[CAS_LSB +: 3];

    // Length and ordering decode
    always_comb begin
        cfg    = '0;
        len_ok = 1'b1;
        case (len_code)
            3'b000, 3'b001, 3'b010, 3'b011: cfg.len_log2 = len_code[1:0];
            LEN_CODE_FULL:                  cfg.full_page = 1'b1;
            default:                        len_ok = 1'b0;
        endcase
        cfg.interleave = mode_word[TYPE_BIT] & ~cfg.full_page;
    end

    // CAS latency decode
    always_comb begin
        cas_ok  = (cas_code == 3'd1) || (cas_code == 3'd2) || (cas_code == 3'd3);
        cas_lat = cas_ok ? cas_code[1:0] : 2'd0;
    end

    // Beat count and legality
    always_comb begin
        if (cfg.full_page)
            burst_beats = (COL_W+1)'(1) << COL_W;
        else
            burst_beats = (COL_W+1)'(1) << cfg.len_log2;
        mode_legal = len_ok & cas_ok;
    end
endmodule

// File: rtl/sdram_beat_ctrl.sv
// Tracks the running burst: captures start column and settings, counts beats,
// and ends the burst on the last beat or on stop. Start wins over stop.
module sdram_beat_ctrl
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  logic [COL_W-1:0] start_col,
    input  burst_cfg_t       cfg_in,
    output logic             active,
    output logic [COL_W-1:0] beat,
    output logic [COL_W-1:0] base,
    output logic [COL_W-1:0] low_mask,
    output burst_cfg_t       cfg_q,
    output logic             last
);
    // Mask of the address bits that move within the burst
    always_comb begin
        if (cfg_q.full_page)
            low_mask = '1;
        else
            low_mask = (COL_W'(1) << cfg_q.len_log2) - COL_W'(1);
    end

    // Final beat of a fixed-length burst
    assign last = active & ~cfg_q.full_page & (beat == low_mask);

    // Burst state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
            base   <= '0;
            cfg_q  <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
            base   <= start_col;
            cfg_q  <= cfg_in;
        end else if (active) begin
            if (stop || last)
                active <= 1'b0;
            else
                beat <= beat + COL_W'(1);
        end
    end
endmodule

// File: rtl/sdram_col_order.sv
// Forms the column of the current beat: bits under the mask follow the
// sequential sum or the interleaved XOR, the rest keep the start column.
module sdram_col_order #(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  logic [COL_W-1:0] low_mask,
    input  logic             interleave,
    output logic [COL_W-1:0] col
);
    logic [COL_W-1:0] seq_sum;

    assign seq_sum = base + beat;

    // Per-bit selection between fixed, sequential and interleaved
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        assign col[i] = low_mask[i] ? (interleave ? (base[i] ^ beat[i]) : seq_sum[i])
                                    : base[i];
    end
endmodule

// File: rtl/sdram_burst_colgen.sv
// Top of the burst column generator: mode decode, burst state and column
// ordering. Outputs follow the captured state; decode outputs follow mode_word.
module sdram_burst_colgen
    import sdram_colgen_pkg::*;
#(
    parameter int COL_W  = 8,
    parameter int MODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              start,
    input  logic [COL_W-1:0]  start_col,
    input  logic              stop,
    output logic [COL_W-1:0]  col_out,
    output logic              col_valid,
    output logic              col_last,
    output logic [1:0]        cas_lat,
    output logic [COL_W:0]    burst_beats,
    output logic              interleave,
    output logic              full_page,
    output logic              mode_legal
);
    burst_cfg_t       dec_cfg;
    burst_cfg_t       run_cfg;
    logic             active;
    logic             last;
    logic             run_full;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] base;
    logic [COL_W-1:0] low_mask;

    sdram_mode_decode #(.COL_W(COL_W), .MODE_W(MODE_W)) u_decode (
        .mode_word   (mode_word),
        .cfg         (dec_cfg),
        .cas_lat     (cas_lat),
        .burst_beats (burst_beats),
        .mode_legal  (mode_legal)
    );

    sdram_beat_ctrl #(.COL_W(COL_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .stop      (stop),
        .start_col (start_col),
        .cfg_in    (dec_cfg),
        .active    (active),
        .beat      (beat),
        .base      (base),
        .low_mask  (low_mask),
        .cfg_q     (run_cfg),
        .last      (last)
    );

    sdram_col_order #(.COL_W(COL_W)) u_order (
        .base       (base),
        .beat       (beat),
        .low_mask   (low_mask),
        .interleave (run_cfg.interleave),
        .col        (col_out)
    );

    assign interleave = dec_cfg.interleave;
    assign full_page  = dec_cfg.full_page;
    assign col_valid  = active;
    assign col_last   = last;
    assign run_full   = run_cfg.full_page;
endmodule

// File: rtl/sdram_colgen_checker.sv
// Temporal checks on the burst column generator, attached by bind.
// Assumes COL_W > 3 so the bits above an 8-beat window exist.
module sdram_colgen_checker #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic             stop,
    input logic [COL_W-1:0] start_col,
    input logic [COL_W-1:0] col_out,
    input logic             col_valid,
    input logic             col_last,
    input logic             run_full
);
    assert_first_col_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (col_valid && col_out == $past(start_col)));

    assert_last_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
        col_last |-> col_valid);

    assert_idle_after_last_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (col_last && !start) |=> !col_valid);

    assert_stop_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !col_valid);

    // R3 and R4: bits above the widest fixed window do not move
    assert_upper_fixed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && !start && !stop && !col_last && !run_full) |=>
        (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

    assert_full_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid && run_full && !start && !stop) |=>
        (col_out == COL_W'($past(col_out) + COL_W'(1)) && !col_last));

    assert_reset_idle_R9: assert property (@(posedge clk)
        !rst_n |=> (!col_valid && !col_last));
endmodule

bind sdram_burst_colgen sdram_colgen_checker #(.COL_W(COL_W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .start_col (start_col),
    .col_out   (col_out),
    .col_valid (col_valid),
    .col_last  (col_last),
    .run_full  (run_full)
);

// File: tb/tb_sdram_burst_colgen.sv
// Bench: behavioural reference model updated on each rising edge and
// compared with the outputs on every falling edge; directed decode checks.
module tb_sdram_burst_colgen;
    localparam int COLS = 256;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] mode_word;
    logic       start;
    logic [7:0] start_col;
    logic       stop;
    logic [7:0] col_out;
    logic       col_valid;
    logic       col_last;
    logic [1:0] cas_lat;
    logic [8:0] burst_beats;
    logic       interleave;
    logic       full_page;
    logic       mode_legal;

    int    checks = 0;
    int    errors = 0;
    int    cyc = 0;
    bit    comparing = 0;
    bit    finished = 0;
    string tag = "R9";

    // model state
    bit m_active = 0;
    int m_beat = 0;
    int m_bl = 1;
    bit m_il = 0;
    int m_base = 0;

    always #10 clk = ~clk;

    sdram_burst_colgen dut (
        .clk (clk), .rst_n (rst_n), .mode_word (mode_word), .start (start),
        .start_col (start_col), .stop (stop), .col_out (col_out),
        .col_valid (col_valid), .col_last (col_last), .cas_lat (cas_lat),
        .burst_beats (burst_beats), .interleave (interleave),
        .full_page (full_page), .mode_legal (mode_legal)
    );

    function automatic int len_of(int code);
        if (code <= 3) return 1 << code;
        if (code == 7) return 0;
        return 1;
    endfunction

    function automatic int exp_col(int b, int k, int bl, bit il);
        int lo;
        if (bl == 0) return (b + k) % COLS;
        lo = b % bl;
        if (il) return (b - lo) + (lo ^ k);
        return (b - lo) + ((lo + k) % bl);
    endfunction

    task automatic check(string req, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d at cycle %0d", req, what, act, exp, cyc);
        end
    endtask

    // reference model update
    always @(posedge clk) begin
        cyc++;
        if (!rst_n) m_active = 0;
        else if (start) begin
            m_active = 1; m_beat = 0; m_base = start_col;
            m_bl = len_of(mode_word[2:0]);
            m_il = mode_word[3] && (m_bl != 0);
        end else if (m_active) begin
            if (stop || (m_bl != 0 && m_beat == m_bl - 1)) m_active = 0;
            else m_beat = (m_beat + 1) % COLS;
        end
        if (cyc > 50000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (comparing) begin
            check(tag, col_valid, m_active, "col_valid");
            check("R6", col_last, m_active && m_bl != 0 && m_beat == m_bl - 1, "col_last");
            if (m_active)
                check(tag, col_out, exp_col(m_base, m_beat, m_bl, m_il), "col_out");
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic run_burst(int code, bit il, int col);
        tag = il ? "R4" : "R3";
        mode_word = {3'd2, il, 3'(code)};
        start_col = 8'(col);
        start = 1;
        tick();
        start = 0;
        check("R2", col_out, col, "first col_out");
        check("R2", col_valid, 1, "first col_valid");
        repeat (10) tick();
    endtask

    initial begin
        rst_n = 0; mode_word = '0; start = 0; start_col = '0; stop = 0;
        repeat (3) tick();
        check("R9", col_valid, 0, "reset col_valid");
        check("R9", col_last, 0, "reset col_last");
        comparing = 1;
        rst_n = 1;
        tick();

        // R1 decode across all length and latency codes, both orderings
        for (int lc = 0; lc < 8; lc++) begin
            for (int cc = 0; cc < 8; cc++) begin
                for (int t = 0; t < 2; t++) begin
                    int  bl;
                    bit  cas_ok;
                    bit  len_ok;
                    mode_word = {3'(cc), 1'(t), 3'(lc)};
                    #1;
                    bl = len_of(lc);
                    cas_ok = (cc >= 1 && cc <= 3);
                    len_ok = (lc <= 3 || lc == 7);
                    check("R1", cas_lat, cas_ok ? cc : 0, "cas_lat");
                    check("R1", burst_beats, bl == 0 ? 256 : bl, "burst_beats");
                    check("R1", full_page, bl == 0, "full_page");
                    check("R1", interleave, t == 1 && bl != 0, "interleave");
                    check("R1", mode_legal, cas_ok && len_ok, "mode_legal");
                end
            end
        end
        tick();

        // R3 R4 R6: fixed lengths, both orderings, several start columns
        for (int lc = 0; lc < 4; lc++)
            for (int t = 0; t < 2; t++) begin
                run_burst(lc, t[0], 8'h00);
                run_burst(lc, t[0], 8'h35);
                run_burst(lc, t[0], 8'hFE);
            end
        // R1: illegal length code behaves as one beat
        tag = "R1";
        mode_word = 7'b010_0_101; start_col = 8'h77; start = 1;
        tick(); start = 0;
        check("R1", col_last, 1, "illegal length last");
        repeat (3) tick();

        // R5: full page wraps past 255, ordering bit ignored
        tag = "R5";
        mode_word = 7'b011_1_111; start_col = 8'hF0; start = 1;
        tick(); start = 0;
        repeat (300) tick();
        check("R5", col_valid, 1, "full page still running");
        tag = "R7";
        stop = 1; tick(); stop = 0;
        check("R7", col_valid, 0, "full page stopped");
        repeat (3) tick();

        // R7: stop mid fixed burst, and stop while idle
        mode_word = 7'b010_0_011; start_col = 8'h41; start = 1;
        tick(); start = 0;
        repeat (2) tick();
        stop = 1; tick(); stop = 0;
        check("R7", col_valid, 0, "stop mid burst");
        stop = 1; repeat (3) tick(); stop = 0;
        check("R7", col_valid, 0, "stop idle");

        // R8: back-to-back starts and start with stop
        tag = "R8";
        mode_word = 7'b001_0_010;
        for (int i = 0; i < 5; i++) begin
            start_col = 8'(8'h10 + 8'(i * 7)); start = 1; tick();
            check("R8", col_out, 8'h10 + i * 7, "restart col");
        end
        start = 0; tick();
        start_col = 8'hA3; start = 1; stop = 1; tick();
        start = 0; stop = 0;
        check("R8", col_valid, 1, "start beats stop");
        check("R8", col_out, 8'hA3, "start beats stop col");
        repeat (6) tick();

        // R10: mode change during a burst has no effect
        tag = "R10";
        mode_word = 7'b011_1_011; start_col = 8'h2B; start = 1;
        tick(); start = 0;
        mode_word = 7'b001_0_001;
        repeat (3) tick();
        check("R10", col_out, 8'h28 + (3 ^ 3), "captured interleave beat 3");
        repeat (8) tick();

        comparing = 0;
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule